// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block is a byte-wide working memory of 2048 words with a hidden nonvolatile twin of every word. An access port with chip enable, write enable and output enable reads and writes the working array, one access per clock. The working array is copied into the nonvolatile twin (a STORE) or refilled from it (a RECALL) only when a fixed series of read addresses appears on that same port. No separate command pin exists.

A STORE or RECALL is atomic from outside. While it runs, `busy` is high, `ready` is low, and the port ignores everything presented to it. Each transfer holds the port for a fixed number of cycles. That count comes from the clock frequency and the allowed transfer time. A power-up reset always starts a RECALL, so the working array holds the preserved contents before the first access is accepted.

Back-pressure: a request is the pair `ce` plus the other inputs. It is taken on a rising edge only while `ready` is high. A request presented while `ready` is low is dropped, not held. The block has no buffer, so the host must repeat the request later. Read data carries no back-pressure: `rd_valid` is a one-cycle pulse.

Top module: `nvsram_ctrl`

## Requirements
- R1: A read accepted on an edge (ce=1, we=0, oe=1, ready=1) raises `rd_valid` for one cycle after that edge. `rdata` then carries the working word at that address, including a value written by any earlier accepted write.
- R2: An accepted write (ce=1, we=1) updates one word. An accepted read with oe=0 changes no word and leaves `rd_valid` low. Whenever `rd_valid` is low, `rdata` is 0.
- R3: `ready` is the inverse of `busy`. While `busy` is high, no write changes the working array and no read raises `rd_valid`.
- R4: The trigger is six consecutive accepted reads. The first five use addresses 'h155, 'h2AA, 'h0F0, 'h70F, 'h3C3, in that order. A sixth read of 'h4B4 starts a STORE, and a sixth read of 'h1E1 starts a RECALL.
- R5: An accepted access that does not fit the next step cancels the series. A write always cancels it, and so does a read of any other address. The cancelling access is then judged as a possible first step, so a read of 'h155 restarts the series at step two.
- R6: The six trigger reads return normal working-array data. `busy` rises in the cycle right after the edge that accepted the sixth read.
- R7: A STORE copies every working word into the nonvolatile array and leaves the working array unchanged.
- R8: A RECALL first clears the working array and then loads it with the nonvolatile contents. The nonvolatile array is left unchanged, so repeated RECALLs give the same result.
- R9: While reset is asserted `busy` is high. After release a RECALL runs, and `busy` stays high through the first RECALL_CYC rising edges.
- R10: `busy` lasts exactly STORE_CYC = CLK_MHZ*STORE_US cycles for a STORE and RECALL_CYC = CLK_MHZ*RECALL_US cycles for a RECALL.
- R11: While `busy` is high the trigger series does not advance. Detection starts again from step one once `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Power-up reset, active low, asynchronous assert |
| ce | input | 1 | Request valid (chip enable) |
| we | input | 1 | 1 = write, 0 = read |
| oe | input | 1 | Read result is returned only when high |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| ready | output | 1 | Request is accepted on this edge when high |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rdata | output | DATA_W | Read data, zero when rd_valid is low |
| busy | output | 1 | Nonvolatile transfer in progress |

## Verification
Read results appear one edge after the accepting edge. `busy` rises one edge after the sixth trigger read and stays high for exactly the transfer cycle count. After a reset release, `busy` falls on the RECALL_CYC-th edge. The bench drives inputs shortly after the falling clock edge. On every rising edge, a behavioural reference advances its state from those inputs. On every falling edge, the reference's expected `busy`, `ready`, `rd_valid` and `rdata` are compared with the outputs, so each result is checked in the cycle it is due. Directed counts of `busy` length back this up for STORE.

// File: rtl/nvs_pkg.sv
`timescale 1ns/1ps
package nvs_pkg;

  // number of shared leading steps in the trigger series
  localparam int PREFIX_LEN = 5;

  typedef enum logic [2:0] {
    XF_IDLE,
    XF_STORE,
    XF_CLEAR,
    XF_LOAD,
    XF_HOLD
  } xfer_phase_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_STORE,
    CMD_RECALL
  } nv_cmd_e;

endpackage

// File: rtl/nvs_word_array.sv
`timescale 1ns/1ps
// Plain word array: one synchronous write port, one combinational read port.
module nvs_word_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvs_seq_detect.sv
`timescale 1ns/1ps
// Watches accepted accesses for the six-read trigger series.
module nvs_seq_detect
  import nvs_pkg::*;
#(
  parameter int AW = 11,
  parameter logic [AW-1:0] SEQ [PREFIX_LEN] = '{default: '0},
  parameter logic [AW-1:0] STORE_ADDR  = '0,
  parameter logic [AW-1:0] RECALL_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          acc_valid,
  input  logic          acc_read,
  input  logic [AW-1:0] acc_addr,
  output nv_cmd_e       cmd
);
  localparam int SW = $clog2(PREFIX_LEN + 1);
  localparam logic [SW-1:0] FINAL_STEP = SW'(PREFIX_LEN);

  logic [SW-1:0]         step_q, step_d;
  logic [PREFIX_LEN-1:0] hit;
  logic                  step_hit;
  logic [SW-1:0]         restart;

  for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_hit
    assign hit[i] = acc_read && (acc_addr == SEQ[i]);
  end

  always_comb begin
    step_hit = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (step_q == SW'(i)) step_hit = hit[i];
    end
  end

  // a cancelling access may itself be the first step of a new series
  assign restart = {{(SW-1){1'b0}}, hit[0]};

  always_comb begin
    cmd    = CMD_NONE;
    step_d = step_q;
    if (hold) begin
      step_d = '0;
    end else if (acc_valid) begin
      if (step_q == FINAL_STEP) begin
        if (acc_read && acc_addr == STORE_ADDR)       cmd = CMD_STORE;
        else if (acc_read && acc_addr == RECALL_ADDR) cmd = CMD_RECALL;
        step_d = (cmd != CMD_NONE) ? '0 : restart;
      end else if (step_hit) begin
        step_d = step_q + 1'b1;
      end else begin
        step_d = restart;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end
endmodule

// File: rtl/nvs_xfer_engine.sv
`timescale 1ns/1ps
// Walks the word pointer through a STORE or the two RECALL passes and
// holds busy until the transfer's cycle budget is spent.
module nvs_xfer_engine
  import nvs_pkg::*;
#(
  parameter int AW         = 11,
  parameter int STORE_CYC  = 2500000,
  parameter int RECALL_CYC = 5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  nv_cmd_e       cmd,
  output xfer_phase_e   phase,
  output logic [AW-1:0] ptr,
  output logic          busy
);
  localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] STORE_LOAD  = TW'(STORE_CYC - 1);
  localparam logic [TW-1:0] RECALL_LOAD = TW'(RECALL_CYC - 1);

  logic [TW-1:0] timer_q;
  logic          last_word;

  assign last_word = &ptr;
  assign busy      = (phase != XF_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= XF_CLEAR;
      ptr     <= '0;
      timer_q <= RECALL_LOAD;
    end else begin
      if (phase != XF_IDLE && timer_q != '0) timer_q <= timer_q - 1'b1;
      unique case (phase)
        XF_IDLE: begin
          ptr <= '0;
          if (cmd == CMD_STORE) begin
            phase   <= XF_STORE;
            timer_q <= STORE_LOAD;
          end else if (cmd == CMD_RECALL) begin
            phase   <= XF_CLEAR;
            timer_q <= RECALL_LOAD;
          end
        end
        XF_STORE: begin
          ptr <= ptr + 1'b1;
          if (last_word) phase <= XF_HOLD;
        end
        XF_CLEAR: begin
          ptr <= ptr + 1'b1;
          if (last_word) phase <= XF_LOAD;
        end
        XF_LOAD: begin
          ptr <= ptr + 1'b1;
          if (last_word) phase <= XF_HOLD;
        end
        XF_HOLD: begin
          if (timer_q == '0) phase <= XF_IDLE;
        end
        default: phase <= XF_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvsram_ctrl.sv
`timescale 1ns/1ps
module nvsram_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int CLK_MHZ   = 250,
  parameter int STORE_US  = 10000,
  parameter int RECALL_US = 20,
  parameter logic [ADDR_W-1:0] TRIG_SEQ [PREFIX_LEN] =
    '{11'h155, 11'h2AA, 11'h0F0, 11'h70F, 11'h3C3},
  parameter logic [ADDR_W-1:0] TRIG_STORE  = 11'h4B4,
  parameter logic [ADDR_W-1:0] TRIG_RECALL = 11'h1E1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int STORE_CYC  = CLK_MHZ * STORE_US;
  localparam int RECALL_CYC = CLK_MHZ * RECALL_US;

  xfer_phase_e       phase;
  logic [ADDR_W-1:0] ptr;
  nv_cmd_e           cmd;
  logic              accept;

  logic              wk_we;
  logic [ADDR_W-1:0] wk_waddr, wk_raddr;
  logic [DATA_W-1:0] wk_wdata, wk_rdata;
  logic [DATA_W-1:0] sh_rdata;

  assign ready  = ~busy;
  assign accept = ce & ready;

  nvs_seq_detect #(
    .AW(ADDR_W), .SEQ(TRIG_SEQ),
    .STORE_ADDR(TRIG_STORE), .RECALL_ADDR(TRIG_RECALL)
  ) u_detect (
    .clk(clk), .rst_n(rst_n), .hold(busy),
    .acc_valid(accept), .acc_read(~we), .acc_addr(addr),
    .cmd(cmd)
  );

  nvs_xfer_engine #(
    .AW(ADDR_W), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .phase(phase), .ptr(ptr), .busy(busy)
  );

  // working-array port steering: transfer passes own it while busy
  always_comb begin
    unique case (phase)
      XF_CLEAR: begin
        wk_we    = 1'b1;
        wk_waddr = ptr;
        wk_wdata = '0;
      end
      XF_LOAD: begin
        wk_we    = 1'b1;
        wk_waddr = ptr;
        wk_wdata = sh_rdata;
      end
      default: begin
        wk_we    = accept & we;
        wk_waddr = addr;
        wk_wdata = wdata;
      end
    endcase
    wk_raddr = (phase == XF_STORE) ? ptr : addr;
  end

  nvs_word_array #(.AW(ADDR_W), .DW(DATA_W)) u_working (
    .clk(clk), .we(wk_we), .waddr(wk_waddr), .wdata(wk_wdata),
    .raddr(wk_raddr), .rdata(wk_rdata)
  );

  nvs_word_array #(.AW(ADDR_W), .DW(DATA_W)) u_shadow (
    .clk(clk), .we(phase == XF_STORE), .waddr(ptr), .wdata(wk_rdata),
    .raddr(ptr), .rdata(sh_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= accept & ~we & oe;
      rdata    <= (accept & ~we & oe) ? wk_rdata : '0;
    end
  end

  // DEPTH is kept for readers sizing the transfer budget against the passes
  logic unused_depth;
  assign unused_depth = (DEPTH == 0);
endmodule

// File: rtl/nvs_checker.sv
`timescale 1ns/1ps
module nvs_checker #(
  parameter int DATA_W     = 8,
  parameter int STORE_CYC  = 2500000,
  parameter int RECALL_CYC = 5000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce,
  input logic              we,
  input logic              oe,
  input logic              ready,
  input logic              busy,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rdata
);
  int unsigned span;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    span <= 0;
    else if (busy) span <= span + 1;
    else           span <= 0;
  end

  assert_read_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !we && oe && ready) |=> rd_valid);

  assert_oe_low_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !we && !oe) |=> !rd_valid);

  assert_zero_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rdata == '0));

  assert_locked_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ce) |=> !rd_valid);

  assert_start_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ce && !we && ready));

  assert_busy_span_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (span == STORE_CYC || span == RECALL_CYC));
endmodule

bind nvsram_ctrl nvs_checker #(
  .DATA_W(DATA_W), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)
) u_nvs_checker (
  .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .oe(oe),
  .ready(ready), .busy(busy), .rd_valid(rd_valid), .rdata(rdata)
);

// File: tb/test_nvsram_ctrl.sv
`timescale 1ns/1ps
module test_nvsram_ctrl;
  localparam int AW = 11;
  localparam int DEPTH = 2048;
  localparam int CLK_MHZ = 250;
  localparam int STORE_US = 40;
  localparam int RECALL_US = 20;
  localparam int ST_CYC = CLK_MHZ * STORE_US;
  localparam int RC_CYC = CLK_MHZ * RECALL_US;
  // trigger addresses as given in R4
  localparam logic [AW-1:0] SQ0 = 11'h155, SQ1 = 11'h2AA, SQ2 = 11'h0F0,
                            SQ3 = 11'h70F, SQ4 = 11'h3C3;
  localparam logic [AW-1:0] SQ_ST = 11'h4B4, SQ_RC = 11'h1E1;

  logic clk = 0, rst_n = 0, ce = 0, we = 0, oe = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ready, rd_valid, busy;
  logic [7:0] rdata;

  always #2 clk = ~clk;

  nvsram_ctrl #(.CLK_MHZ(CLK_MHZ), .STORE_US(STORE_US), .RECALL_US(RECALL_US))
    i_nvsram_ctrl (.clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .oe(oe),
                   .addr(addr), .wdata(wdata), .ready(ready),
                   .rd_valid(rd_valid), .rdata(rdata), .busy(busy));

  int checks = 0, errors = 0;
  string cur_req = "R9";

  // behavioural reference
  logic [7:0] m_mem [DEPTH];
  logic [7:0] m_sh  [DEPTH];
  bit m_kn [DEPTH];
  bit m_shk [DEPTH];
  int m_cnt = RC_CYC;
  int m_step = 0;
  bit e_rv = 0;
  logic [7:0] e_rd = '0;
  bit e_kn = 1;
  bit started = 0;
  logic [AW-1:0] seqv [5] = '{SQ0, SQ1, SQ2, SQ3, SQ4};

  initial for (int i = 0; i < DEPTH; i++) begin m_kn[i] = 0; m_shk[i] = 0; end

  always @(posedge clk) begin : model
    bit acc, rd, n_rv, n_kn;
    logic [7:0] n_rd;
    int fire;
    started = 1;
    if (!rst_n) begin
      m_cnt = RC_CYC; m_step = 0; e_rv = 0; e_rd = '0; e_kn = 1;
      for (int i = 0; i < DEPTH; i++) begin m_mem[i] = m_sh[i]; m_kn[i] = m_shk[i]; end
    end else begin
      acc = ce && (m_cnt == 0);
      rd = !we;
      n_rv = acc && rd && oe;
      n_rd = n_rv ? m_mem[addr] : 8'h00;
      n_kn = n_rv ? m_kn[addr] : 1'b1;
      if (acc && we) begin m_mem[addr] = wdata; m_kn[addr] = 1; end
      fire = 0;
      if (m_cnt != 0) m_step = 0;
      else if (acc) begin
        if (m_step == 5) begin
          if (rd && addr == SQ_ST) fire = 1;
          else if (rd && addr == SQ_RC) fire = 2;
          m_step = (fire != 0) ? 0 : ((rd && addr == SQ0) ? 1 : 0);
        end else if (rd && addr == seqv[m_step]) m_step++;
        else m_step = (rd && addr == SQ0) ? 1 : 0;
      end
      if (m_cnt > 0) m_cnt--;
      if (fire == 1) begin
        for (int i = 0; i < DEPTH; i++) begin m_sh[i] = m_mem[i]; m_shk[i] = m_kn[i]; end
        m_cnt = ST_CYC;
      end else if (fire == 2) begin
        for (int i = 0; i < DEPTH; i++) begin m_mem[i] = m_sh[i]; m_kn[i] = m_shk[i]; end
        m_cnt = RC_CYC;
      end
      e_rv = n_rv; e_rd = n_rd; e_kn = n_kn;
    end
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(busy === (m_cnt != 0), "busy", int'(busy), int'(m_cnt != 0));
      chk(ready === (m_cnt == 0), "ready", int'(ready), int'(m_cnt == 0));
      chk(rd_valid === e_rv, "rd_valid", int'(rd_valid), int'(e_rv));
      if (!e_rv) chk(rdata === 8'h00, "rdata idle", int'(rdata), 0);
      else if (e_kn) chk(rdata === e_rd, "rdata", int'(rdata), int'(e_rd));
    end
  end

  task automatic drv(bit c, bit w, bit o, logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); #1;
    ce = c; we = w; oe = o; addr = a; wdata = d;
  endtask
  task automatic idle(int n); repeat (n) drv(0, 0, 0, '0, '0); endtask
  task automatic rd_w(logic [AW-1:0] a); drv(1, 0, 1, a, '0); endtask
  task automatic wr_w(logic [AW-1:0] a, logic [7:0] d); drv(1, 1, 0, a, d); endtask
  task automatic trig(logic [AW-1:0] last);
    rd_w(SQ0); rd_w(SQ1); rd_w(SQ2); rd_w(SQ3); rd_w(SQ4); rd_w(last);
  endtask
  task automatic wait_idle;
    do idle(1); while (busy === 1'b1);
    idle(2);
  endtask
  task automatic pulse_reset;
    @(negedge clk); #1; rst_n = 0;
    idle(3);
    @(negedge clk); #1; rst_n = 1;
  endtask
  function automatic logic [7:0] patt(int a, int k);
    return 8'((a * 37 + k * 11) ^ (a >> 3));
  endfunction

  task automatic main_seq;
    int n;
    cur_req = "R9";
    idle(4);
    @(negedge clk); #1; rst_n = 1;
    wait_idle();
    cur_req = "R1";
    for (int a = 0; a < DEPTH; a++) wr_w(a[AW-1:0], patt(a, 1));
    for (int a = 0; a < 64; a++) rd_w(11'((a * 97 + 3) % DEPTH));
    cur_req = "R2";
    for (int a = 0; a < 8; a++) drv(1, 0, 0, 11'(a * 5), '0);
    wr_w(11'd9, 8'h5A); rd_w(11'd9); idle(2);
    cur_req = "R6";
    trig(SQ_ST);
    cur_req = "R10";
    n = 0;
    do begin @(negedge clk); if (busy === 1'b1) n++; end while (busy === 1'b1);
    chk(n == ST_CYC, "store busy length", n, ST_CYC);
    idle(3);
    cur_req = "R7";
    for (int a = 0; a < DEPTH; a++) wr_w(a[AW-1:0], patt(a, 2));
    for (int a = 0; a < 32; a++) rd_w(11'(a * 61));
    cur_req = "R5";
    rd_w(SQ0); rd_w(SQ1); rd_w(SQ2); wr_w(11'd7, 8'hC3); rd_w(SQ3); rd_w(SQ4); rd_w(SQ_ST);
    idle(3);
    rd_w(SQ0); rd_w(SQ1); rd_w(11'd12); rd_w(SQ2); rd_w(SQ3); rd_w(SQ4); rd_w(SQ_RC);
    idle(3);
    cur_req = "R4";
    rd_w(SQ0); rd_w(SQ1); rd_w(SQ0); rd_w(SQ1); rd_w(SQ2); rd_w(SQ3); rd_w(SQ4); rd_w(SQ_RC);
    cur_req = "R3";
    wr_w(11'd5, 8'hEE); rd_w(11'd5); rd_w(11'd100);
    cur_req = "R11";
    trig(SQ_ST);
    wait_idle();
    rd_w(SQ_ST); idle(4);
    cur_req = "R8";
    for (int a = 0; a < DEPTH; a++) rd_w(a[AW-1:0]);
    for (int a = 0; a < 16; a++) wr_w(11'(a * 3), 8'hA0 + 8'(a));
    trig(SQ_RC);
    wait_idle();
    for (int a = 0; a < DEPTH; a++) rd_w(a[AW-1:0]);
    cur_req = "R9";
    wr_w(11'd1, 8'h11);
    pulse_reset();
    wait_idle();
    for (int a = 0; a < DEPTH; a++) rd_w(a[AW-1:0]);
    idle(2);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, run hung");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule